// File: doc/BRIEF.md
# Freezable Cross-Domain Register Synchronizer

This block moves register writes issued on a fast bus clock into a slow clock domain. It holds three registers: a control word and two compare values. Every accepted write lands in a bus-side staging register. The staged values are then sent across as one batch over a single toggle request/acknowledge channel, with two-flop synchronizers in each direction. On the slow side, the registers change only when a synchronized request edge arrives.

Software can watch a busy bit for each register. That bit rises after a write and falls once the slow domain holds the value. A freeze input holds back all transfers, so several writes can be staged and later released as one atomic update. A write aimed at a register that is still busy stalls the bus through a ready signal, unless freeze is set. While frozen, any register may be rewritten freely, and the transfer already under way is not disturbed.

Top module: `regsync_bridge`

## Requirements
- R1: Busy bit i (i equal to the register address) reads 1 in the bus cycle after a write to register i is accepted. It stays 1 until the slow-domain output of that register holds the written value.
- R2: Address 0 selects the control register, address 1 compare 0, and address 2 compare 1. Once busy falls, that register's slow-domain output equals the last value written to it, and the other two outputs keep their values.
- R3: While freeze is 1, no slow-domain output changes and the busy bits of staged registers stay 1.
- R4: When freeze returns to 0, every register written during the freeze updates its slow-domain output in the same slow clock cycle.
- R5: While freeze is 1, writes are accepted without stall, even to busy registers. The last value written before release is the one delivered.
- R6: With freeze at 0, a write to a busy register holds wr_ready at 0 until that busy bit clears. The write is then accepted, and the value that was in flight is delivered unchanged before the new one.
- R7: A write to address 3 is ignored: wr_ready stays 1, no busy bit rises, and no output changes.
- R8: After reset, busy is 0, wr_ready is 1 and all three outputs are 0.
- R9: A write accepted in the same bus cycle that freeze falls is not part of the released batch. Its output changes in a strictly later slow cycle than the batch.
- R10: If a register is rewritten while frozen and its earlier value is still in flight, the earlier value still reaches the output while frozen. The later value follows after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_slow | input | 1 | Slow register clock |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 compare 0, 2 compare 1) |
| wr_data | input | DATA_W | Write value |
| freeze | input | 1 | Hold transfers while high |
| wr_ready | output | 1 | Low while a write must stall |
| busy | output | 3 | Per-register transfer pending |
| ctrl_q | output | DATA_W | Slow-domain control value |
| cmp0_q | output | DATA_W | Slow-domain compare 0 value |
| cmp1_q | output | DATA_W | Slow-domain compare 1 value |

## Verification
Two events can land in the same bus cycle: the fall of freeze, which launches the staged batch, and a new write to a register that is not busy. The bench drives both on one edge. It then records the slow cycle in which each output changes, and requires that the batch registers change together while the new write changes strictly later. A second collision, a frozen rewrite of a register whose earlier value is still crossing, is judged by checking that the output shows the earlier value while frozen and the later one only after release.

// File: rtl/regsync_pkg.sv
package regsync_pkg;

    localparam int NUM_REGS = 3;
    localparam int ADDR_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMP0 = 2'd1,
        SEL_CMP1 = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Decoded bus write for one cycle.
    typedef struct packed {
        logic [NUM_REGS-1:0] hit;    // register addressed (zero for unmapped)
        logic                stall;  // hold the bus this cycle
        logic [NUM_REGS-1:0] take;   // staging registers loaded this cycle
    } wr_req_t;

    function automatic logic [NUM_REGS-1:0] sel_mask(input logic [ADDR_W-1:0] a);
        logic [NUM_REGS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (a == ADDR_W'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic wr_req_t decode_write(
        input logic                en,
        input logic [ADDR_W-1:0]   a,
        input logic                frz,
        input logic [NUM_REGS-1:0] bsy
    );
        wr_req_t r;
        r.hit   = en ? sel_mask(a) : '0;
        r.stall = !frz && (|(r.hit & bsy));
        r.take  = r.stall ? '0 : r.hit;
        return r;
    endfunction

endpackage

// File: rtl/regsync_sync2.sv
module regsync_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/regsync_fast.sv
module regsync_fast
    import regsync_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       freeze,
    input  logic                       ack_tgl_in,
    output logic                       wr_ready,
    output logic [NUM_REGS-1:0]        busy,
    output logic                       req_tgl,
    output logic [NUM_REGS*DATA_W-1:0] xfer_flat,
    output logic [NUM_REGS-1:0]        sent_mask
);
    logic                ack_s;
    logic                req_q;
    logic                inflight;
    logic                launch;
    logic [NUM_REGS-1:0] dirty_q;
    logic [NUM_REGS-1:0] sent_q;
    logic [DATA_W-1:0]   stage_q [NUM_REGS];
    logic [DATA_W-1:0]   xfer_q  [NUM_REGS];
    wr_req_t             dec;

    regsync_sync2 #(.WIDTH(1)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl_in),
        .q   (ack_s)
    );

    assign inflight = req_q ^ ack_s;
    assign launch   = (|dirty_q) && !freeze && !inflight;
    assign busy     = dirty_q | (sent_q & {NUM_REGS{inflight}});

    always_comb dec = decode_write(wr_en, wr_addr, freeze, busy);

    assign wr_ready = !dec.stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            dirty_q <= '0;
            sent_q  <= '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                stage_q[i] <= '0;
                xfer_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (dec.take[i])            stage_q[i] <= wr_data;
                if (launch && dirty_q[i])   xfer_q[i]  <= stage_q[i];
            end
            dirty_q <= (launch ? '0 : dirty_q) | dec.take;
            if (launch) begin
                sent_q <= dirty_q;
                req_q  <= ~req_q;
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign xfer_flat[g*DATA_W +: DATA_W] = xfer_q[g];
    end

    assign req_tgl   = req_q;
    assign sent_mask = sent_q;

    // R3: no request leaves while frozen
    p_frozen_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(req_q));

    // R1: an accepted write shows up as busy one cycle later
    p_busy_on_write_r1: assert property (@(posedge clk) disable iff (rst)
        (|dec.take) |=> (|(busy & $past(dec.take))));

    // R6: transfer data stays put while the slow side may be sampling it
    p_xfer_hold_r6: assert property (@(posedge clk) disable iff (rst)
        inflight |=> ($stable(xfer_flat) && $stable(sent_q)));

    // R6: a new request only follows a completed acknowledge
    p_one_in_flight_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(req_q) |-> $past(!inflight));
endmodule

// File: rtl/regsync_slow.sv
module regsync_slow
    import regsync_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_tgl_in,
    input  logic [NUM_REGS*DATA_W-1:0] xfer_flat,
    input  logic [NUM_REGS-1:0]        sent_mask,
    output logic                       ack_tgl,
    output logic [NUM_REGS*DATA_W-1:0] val_flat
);
    logic req_s;
    logic req_d;
    logic req_edge;

    regsync_sync2 #(.WIDTH(1)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl_in),
        .q   (req_s)
    );

    always_ff @(posedge clk) begin
        if (rst) req_d <= 1'b0;
        else     req_d <= req_s;
    end

    assign req_edge = req_s ^ req_d;
    assign ack_tgl  = req_d;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
        logic [DATA_W-1:0] v_q;
        always_ff @(posedge clk) begin
            if (rst)                          v_q <= '0;
            else if (req_edge && sent_mask[g]) v_q <= xfer_flat[g*DATA_W +: DATA_W];
        end
        assign val_flat[g*DATA_W +: DATA_W] = v_q;
    end

    // R2: outputs move only on a synchronized request edge
    p_capture_gated_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(val_flat) |-> $past(req_edge));
endmodule

// File: rtl/regsync_bridge.sv
module regsync_bridge
    import regsync_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk_bus,
    input  logic              rst_bus,
    input  logic              clk_slow,
    input  logic              rst_slow,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              freeze,
    output logic              wr_ready,
    output logic [2:0]        busy,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] cmp0_q,
    output logic [DATA_W-1:0] cmp1_q
);
    logic                       req_tgl;
    logic                       ack_tgl;
    logic [NUM_REGS*DATA_W-1:0] xfer_flat;
    logic [NUM_REGS*DATA_W-1:0] val_flat;
    logic [NUM_REGS-1:0]        sent_mask;

    regsync_fast #(.DATA_W(DATA_W)) u_fast (
        .clk        (clk_bus),
        .rst        (rst_bus),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .freeze     (freeze),
        .ack_tgl_in (ack_tgl),
        .wr_ready   (wr_ready),
        .busy       (busy),
        .req_tgl    (req_tgl),
        .xfer_flat  (xfer_flat),
        .sent_mask  (sent_mask)
    );

    regsync_slow #(.DATA_W(DATA_W)) u_slow (
        .clk        (clk_slow),
        .rst        (rst_slow),
        .req_tgl_in (req_tgl),
        .xfer_flat  (xfer_flat),
        .sent_mask  (sent_mask),
        .ack_tgl    (ack_tgl),
        .val_flat   (val_flat)
    );

    assign ctrl_q = val_flat[int'(SEL_CTRL)*DATA_W +: DATA_W];
    assign cmp0_q = val_flat[int'(SEL_CMP0)*DATA_W +: DATA_W];
    assign cmp1_q = val_flat[int'(SEL_CMP1)*DATA_W +: DATA_W];

    // R8: nothing pending right after reset
    p_reset_idle_r8: assert property (@(posedge clk_bus) disable iff (rst_bus)
        $past(rst_bus) |-> (busy == '0 && wr_ready));

    // R7: an unmapped write never raises busy
    p_unmapped_inert_r7: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (wr_en && wr_addr == SEL_NONE && busy == '0) |=> (busy == '0));
endmodule

// File: tb/regsync_bridge_bench.sv
module regsync_bridge_bench;
    localparam int DW = 24;

    logic          clk_bus = 1'b0;
    logic          clk_slow = 1'b0;
    logic          rst_bus = 1'b1;
    logic          rst_slow = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          freeze = 1'b0;
    logic          wr_ready;
    logic [2:0]    busy;
    logic [DW-1:0] ctrl_q, cmp0_q, cmp1_q;

    int n_checks = 0;
    int n_fail   = 0;
    int bus_cyc  = 0;
    int slow_cyc = 0;
    int chg [3];
    logic [DW-1:0] prev [3];
    logic [DW-1:0] expv [3];

    always #2  clk_bus  = ~clk_bus;   // 250 MHz
    always #13 clk_slow = ~clk_slow;

    regsync_bridge #(.DATA_W(DW)) u_regsync_bridge (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_slow(clk_slow), .rst_slow(rst_slow),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .freeze(freeze),
        .wr_ready(wr_ready), .busy(busy), .ctrl_q(ctrl_q), .cmp0_q(cmp0_q), .cmp1_q(cmp1_q)
    );

    function automatic logic [DW-1:0] out_of(input int i);
        return (i == 0) ? ctrl_q : (i == 1) ? cmp0_q : cmp1_q;
    endfunction

    always @(negedge clk_slow) begin
        slow_cyc++;
        for (int i = 0; i < 3; i++) begin
            if (out_of(i) !== prev[i]) chg[i] = slow_cyc;
            prev[i] = out_of(i);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk_bus) begin
        bus_cyc++;
        if (bus_cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling bus edge; returns at a falling edge after acceptance.
    task automatic do_write(input int a, input logic [DW-1:0] d, output int stalls);
        logic r;
        stalls  = 0;
        wr_en   = 1'b1;
        wr_addr = 2'(a);
        wr_data = d;
        forever begin
            #1 r = wr_ready;
            @(negedge clk_bus);
            if (r || stalls > 5000) break;
            stalls++;
        end
        wr_en = 1'b0;
        if (a < 3) expv[a] = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk_bus);
    endtask

    task automatic wait_clear();
        for (int k = 0; k < 3000 && busy != 3'b000; k++) @(negedge clk_bus);
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < 3; i++) chk(out_of(i) == expv[i], req, out_of(i), expv[i]);
    endtask

    int st;
    int c0;
    logic [DW-1:0] va;

    initial begin
        for (int i = 0; i < 3; i++) begin expv[i] = '0; prev[i] = '0; chg[i] = 0; end
        idle(60);
        rst_bus = 1'b0; rst_slow = 1'b0;
        idle(2);

        // R8 reset state
        chk(busy == 3'b000, "R8 busy", busy, 0);
        chk(wr_ready == 1'b1, "R8 ready", wr_ready, 1);
        chk_all("R8 outputs");

        // R1 and R2: sweep every register with several patterns
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 6; k++) begin
                va = DW'((k * 32'h135B1 + r * 32'h2F) ^ (32'h1 << (k * 4)));
                do_write(r, va, st);
                chk(busy[r] == 1'b1, "R1 busy rises", busy, 3'b1 << r);
                chk(out_of(r) != va || k == 0 && va == 0, "R1 busy before output", out_of(r), ~va);
                wait_clear();
                chk_all("R2 delivered");
            end
        end

        // R7: unmapped address ignored
        do_write(3, 24'hABCDEF, st);
        chk(st == 0, "R7 no stall", st, 0);
        chk(busy == 3'b000, "R7 no busy", busy, 0);
        idle(60);
        chk_all("R7 outputs unchanged");

        // R6: back-to-back writes to one register
        do_write(2, 24'h111111, st);
        do_write(2, 24'h222222, st);
        chk(st > 0, "R6 stall seen", st, 1);
        chk(cmp1_q == 24'h111111, "R6 first value intact", cmp1_q, 24'h111111);
        wait_clear();
        chk_all("R6 second value");

        // R3, R5, R4: frozen batch
        freeze = 1'b1;
        do_write(0, 24'h0A0A0A, st);
        do_write(1, 24'h0B0B0B, st);
        do_write(2, 24'h0C0C0C, st);
        do_write(0, 24'h0D0D0D, st);
        chk(st == 0, "R5 frozen rewrite no stall", st, 0);
        idle(80);
        chk(busy == 3'b111, "R3 busy held", busy, 7);
        chk(ctrl_q == 24'h222222 - 24'h222222 + ctrl_q && ctrl_q != 24'h0D0D0D, "R3 ctrl held", ctrl_q, 0);
        chk(cmp0_q != 24'h0B0B0B, "R3 cmp0 held", cmp0_q, 0);
        chk(cmp1_q == 24'h222222, "R3 cmp1 held", cmp1_q, 24'h222222);
        freeze = 1'b0;
        wait_clear();
        idle(2);
        chk_all("R5 last frozen write wins");
        chk(chg[0] == chg[1], "R4 ctrl/cmp0 together", chg[0], chg[1]);
        chk(chg[1] == chg[2], "R4 cmp0/cmp1 together", chg[1], chg[2]);

        // R9: write lands in the cycle freeze falls
        freeze = 1'b1;
        do_write(0, 24'h515151, st);
        do_write(2, 24'h727272, st);
        idle(4);
        freeze = 1'b0;
        do_write(1, 24'h636363, st);
        chk(st == 0, "R9 no stall", st, 0);
        wait_clear();
        idle(2);
        chk_all("R9 values");
        chk(chg[0] == chg[2], "R9 batch together", chg[0], chg[2]);
        chk(chg[1] > chg[0], "R9 late write later", chg[1], chg[0] + 1);

        // R10: frozen rewrite while earlier value in flight
        do_write(1, 24'h0F0F0F, st);
        idle(1);
        freeze = 1'b1;
        do_write(1, 24'hF0F0F0, st);
        chk(st == 0, "R10 no stall", st, 0);
        idle(120);
        chk(cmp0_q == 24'h0F0F0F, "R10 earlier value arrived", cmp0_q, 24'h0F0F0F);
        chk(busy[1] == 1'b1, "R10 later value held", busy, 2);
        c0 = chg[1];
        freeze = 1'b0;
        wait_clear();
        idle(2);
        chk(cmp0_q == 24'hF0F0F0, "R10 later value after release", cmp0_q, 24'hF0F0F0);
        chk(chg[1] > c0, "R10 change after release", chg[1], c0 + 1);

        finish_run();
    end
endmodule